// File: doc/BRIEF.md
# Two-Bit Counter with Seven-Segment Digit Output

This block is a free-running synchronous counter of two bits. It also drives a seven-segment glyph for the value it holds. On every rising clock edge the count steps up by one and wraps from three back to zero. The only inputs are the clock and a synchronous, active-high clear.

The segment lines are active high and suit a common-cathode display with no inversion. They follow the current count through purely combinational decoding, so a digit appears in the same cycle as the count that produces it.

The clear input is the one exception to that decoding. While it is held, every segment goes dark at once, without waiting for a clock edge. The count itself is only cleared at the next rising edge. Until the first clear has been sampled, the count has no defined value.

Top module: `cseg_counter_top`

## Requirements
- R1: The count is held as two bits, the high bit on `cnt_hi` and the low bit on `cnt_lo`, both changing only on a rising clock edge.
- R2: At each rising edge where `rst` is 0, the count advances by one: 00 to 01, 01 to 10, 10 to 11.
- R3: At a rising edge where `rst` is 1, the count becomes 00 whatever its previous value.
- R4: `seg[6:0]` carries segments {A,B,C,D,E,F,G}, with A on bit 6 and G on bit 0, and a 1 means lit. Segment B (bit 5) is lit exactly when `rst` is 0.
- R5: While `rst` is 1, all seven segment lines are 0 in the same cycle, before any clock edge, and even though the count has not yet changed.
- R6: With `rst` at 0, the segments show the count as follows: 00 gives 1111110, 01 gives 0110000, 10 gives 1101101, and 11 gives 1111001.
- R7: From count 11, a rising edge with `rst` at 0 gives 00, with no intermediate state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear of the count; also blanks the segments combinationally |
| cnt_hi | output | 1 | High bit of the count |
| cnt_lo | output | 1 | Low bit of the count |
| seg | output | 7 | Segment lines {A,B,C,D,E,F,G}, active high |

## Verification
The block has one configuration: a two-bit state and seven segment lines, both fixed by package constants. The bench therefore builds it with exactly those values. With only four states, every digit pattern and every transition, including the wrap from three to zero, can be reached in a few cycles. This also leaves room to raise the clear in the middle of a count, which shows the immediate blanking before the count itself is cleared.

// File: rtl/cseg_pkg.sv
package cseg_pkg;

    localparam int SEG_N = 7;

    typedef struct packed {
        logic hi;
        logic lo;
    } cnt_t;

    typedef logic [SEG_N-1:0] seg_t;

    // Next count: R3 clear takes priority over the R2 advance.
    function automatic cnt_t cnt_next(cnt_t cur, logic clr);
        cnt_t nxt;
        if (clr) begin
            nxt = '0;
        end else begin
            nxt.lo = ~cur.lo;
            nxt.hi = cur.hi ^ cur.lo;
        end
        return nxt;
    endfunction

    // Glyph for the count, segments ordered {A,B,C,D,E,F,G}.
    function automatic seg_t glyph(cnt_t cur);
        logic sa, sb, sc, sd, se, sf, sg;
        sa = ~(~cur.hi & cur.lo);
        sb = 1'b1;
        sc = ~(cur.hi & ~cur.lo);
        sd = sa;
        se = ~cur.lo;
        sf = ~cur.hi & ~cur.lo;
        sg = cur.hi;
        return {sa, sb, sc, sd, se, sf, sg};
    endfunction

endpackage

// File: rtl/cseg_state.sv
module cseg_state
    import cseg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output cnt_t cnt
);

    always_ff @(posedge clk) begin
        cnt <= cnt_next(cnt, rst);
    end

endmodule

// File: rtl/cseg_decode.sv
module cseg_decode
    import cseg_pkg::*;
(
    input  cnt_t cnt,
    input  logic rst,
    output seg_t seg
);

    seg_t raw;

    assign raw = glyph(cnt);

    // Each segment line is gated by the clear input.
    for (genvar i = 0; i < SEG_N; i++) begin : g_blank
        assign seg[i] = raw[i] & ~rst;
    end

endmodule

// File: rtl/cseg_counter_top.sv
module cseg_counter_top
    import cseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic             cnt_hi,
    output logic             cnt_lo,
    output logic [SEG_N-1:0] seg
);

    cnt_t cnt_q;

    cseg_state u_state (
        .clk (clk),
        .rst (rst),
        .cnt (cnt_q)
    );

    cseg_decode u_decode (
        .cnt (cnt_q),
        .rst (rst),
        .seg (seg)
    );

    assign cnt_hi = cnt_q.hi;
    assign cnt_lo = cnt_q.lo;

endmodule

// File: rtl/cseg_chk.sv
module cseg_chk
    import cseg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_hi,
    input logic             cnt_lo,
    input logic [SEG_N-1:0] seg
);

    logic rst_q = 1'b0;

    // R3: the edge after a sampled clear shows count 00.
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r3_clear_zero: assert ({cnt_hi, cnt_lo} == 2'b00);
        end
        rst_q <= rst;
    end

    // R2 and R7: the count steps by one, modulo four.
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> {cnt_hi, cnt_lo} == 2'({$past(cnt_hi), $past(cnt_lo)} + 2'd1));

    // R1: the low bit toggles on every edge that runs free.
    a_r1_lo_toggle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_lo != $past(cnt_lo));

    // R4, R5, R6: checked on the falling edge, away from count updates.
    always @(negedge clk) begin
        if (rst) begin
            a_r5_blank: assert (seg == '0);
        end else begin
            a_r4_b_lit: assert (seg[5] == 1'b1);
            a_r6_min_lit: assert ($countones(seg) >= 2);
        end
    end

endmodule

bind cseg_counter_top cseg_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cnt_hi (cnt_hi),
    .cnt_lo (cnt_lo),
    .seg    (seg)
);

// File: tb/sim_cseg_counter_top.sv
module sim_cseg_counter_top;

    localparam int PERIOD = 10;
    localparam int WATCHDOG_CYC = 5000;

    // Vector table: {hi, lo, seg A..G}, indexed by count value.
    localparam logic [8:0] VEC [4] = '{
        {2'b00, 7'b1111110},
        {2'b01, 7'b0110000},
        {2'b10, 7'b1101101},
        {2'b11, 7'b1111001}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_hi;
    logic       cnt_lo;
    logic [6:0] seg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cseg_counter_top u0 (
        .clk    (clk),
        .rst    (rst),
        .cnt_hi (cnt_hi),
        .cnt_lo (cnt_lo),
        .seg    (seg)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input int idx);
        check(req, {cnt_hi, cnt_lo, seg}, VEC[idx]);
    endtask

    initial begin
        // Reset state (R3, R5)
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 reset count", {cnt_hi, cnt_lo, 7'b0}, 9'b0);
        check("R5 blank in reset", {2'b00, seg}, 9'b0);

        // Release; the digit shows without an edge (R4, R6)
        rst = 1'b0;
        #1;
        check_vec("R6 digit 0", 0);
        check("R4 seg B lit", {8'b0, seg[5]}, 9'd1);

        // Walk the table twice, covering the wrap (R1, R2, R6, R7)
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            check_vec((i % 4 == 0) ? "R7 wrap to 0" : "R2 advance / R6 glyph", i % 4);
        end

        // Count is now 00; step to 10, then clear mid-count
        @(negedge clk);
        @(negedge clk);
        check_vec("R2 at 10", 2);
        rst = 1'b1;
        #1;
        check("R5 blank same cycle", {2'b00, seg}, 9'b0);
        check("R1 count held until edge", {cnt_hi, cnt_lo, 7'b0}, {2'b10, 7'b0});
        check("R4 seg B off in reset", {8'b0, seg[5]}, 9'd0);
        @(negedge clk);
        check("R3 clear from 10", {cnt_hi, cnt_lo, seg}, 9'b0);

        // Clear from 11
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_vec("R2 at 11", 3);
        rst = 1'b1;
        @(negedge clk);
        check("R3 clear from 11", {cnt_hi, cnt_lo, seg}, 9'b0);

        // Clear held for several edges keeps 00
        repeat (3) @(negedge clk);
        check("R3 clear held", {cnt_hi, cnt_lo, seg}, 9'b0);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R2 first step after clear", 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule